// File: doc/BRIEF.md
# Machine-Cycle Clock Divider with Power-Saving Modes

This block derives four-phase machine-cycle timing (phases C1, C2, C3, C4) from the full-speed oscillator clock. It does not gate the clock. It emits one-cycle enable strobes: one strobe per phase, plus a strobe when the machine cycle ends. Downstream logic advances its own state only on these strobes. When software picks a slow mode, each phase is stretched by a fixed factor. The order of the phases and their relative timing stay the same in every mode.

Software controls the block through one 8-bit control register on a simple write-enable and read-back bus. Bits 7:6 select the divider and bit 5 enables automatic return to the fast mode. The slow modes can only be entered from the fast mode.

When automatic return is enabled, any interrupt request or serial-port activity puts the divider back in fast mode. This lets a system idle at low speed and still respond at full speed.

Top module: `mcycle_divider`

## Requirements
- R1: After reset the read-back value is 0x40. Bits 7:6 read 01, bit 5 reads 0, and bits 4:0 read 0. The first machine cycle runs in fast mode.
- R2: The divider-select code sets the number of oscillator clocks per machine cycle. Code 01 gives 4 clocks, code 10 gives 64 and code 11 gives 1024. In each mode every phase lasts one quarter of that count.
- R3: Exactly one bit of `phase_stb[3:0]` is high in the last clock of each phase, in the order bit 0, 1, 2, 3. `mc_end` is high together with bit 3. After reset, the first clock already shows bit 0.
- R4: A write of code 01 to bits 7:6 is accepted in any mode.
- R5: A write of code 10 or 11 is accepted only while bits 7:6 hold 01. Otherwise bits 7:6 keep their value.
- R6: A write of the reserved code 00 leaves bits 7:6 unchanged.
- R7: Bit 5 (switchback enable) takes the written value on every write and reads back as written.
- R8: While bit 5 is 1, any bit of `irq_req` or `ser_act` being high at a clock edge sets bits 7:6 to 01 at that edge, and the read-back shows the change.
- R9: While bit 5 is 0, `irq_req` and `ser_act` have no effect on bits 7:6.
- R10: When a switchback event and a write of bits 7:6 land on the same edge, bits 7:6 become 01.
- R11: A new divider setting takes effect only at a machine-cycle boundary. The machine cycle in progress always completes at its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data: [7:6] divider select, [5] switchback enable |
| reg_rdata | output | 8 | Read-back of the control register |
| irq_req | input | N_IRQ | Interrupt request lines |
| ser_act | input | N_SER | Serial-port activity lines |
| phase_stb | output | 4 | Per-phase enable strobes, bit i for phase C(i+1) |
| mc_end | output | 1 | Machine-cycle-end strobe |

## Verification
The hardest cases to reach are those where a register change and the machine-cycle boundary interact. One is a mode write landing in the middle of a 64-clock cycle. Another is a switchback event arriving on the same edge as a conflicting write. To reach them, the bench first synchronises to the `mc_end` strobe at a falling edge. It then counts a known number of clocks before driving the write or the event, so the exact position inside the machine cycle is fixed. It then measures the full length of the surrounding cycle and the cycle that follows.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [1:0] {
    DIV_RSVD  = 2'b00,
    DIV_FAST  = 2'b01,
    DIV_SLOW1 = 2'b10,
    DIV_SLOW2 = 2'b11
  } div_sel_e;

  // Oscillator clocks per phase for a given selection.
  function automatic int unsigned ticks_per_phase(div_sel_e s,
                                                  int unsigned slow1,
                                                  int unsigned slow2);
    case (s)
      DIV_SLOW1: return slow1;
      DIV_SLOW2: return slow2;
      default:   return 1;
    endcase
  endfunction

  // Legality of a requested selection given the current one.
  function automatic logic sel_write_ok(div_sel_e req, div_sel_e cur);
    return (req == DIV_FAST) ||
           ((req == DIV_SLOW1 || req == DIV_SLOW2) && cur == DIV_FAST);
  endfunction

endpackage

// File: rtl/mcd_ctrl_reg.sv
module mcd_ctrl_reg
  import mcd_pkg::*;
#(
  parameter int N_IRQ = 5,
  parameter int N_SER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       wfield,   // {sel[1:0], swb}
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_SER-1:0] ser_act,
  output div_sel_e         sel,
  output logic             swb,
  output logic             sb_evt,
  output logic             wr_reject
);

  div_sel_e wr_sel;
  logic     wr_accept;

  assign wr_sel    = div_sel_e'(wfield[2:1]);
  assign sb_evt    = swb && ((|irq_req) || (|ser_act));
  assign wr_accept = we && sel_write_ok(wr_sel, sel);
  assign wr_reject = we && !wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= DIV_FAST;
      swb <= 1'b0;
    end else begin
      if (sb_evt)         sel <= DIV_FAST;
      else if (wr_accept) sel <= wr_sel;
      if (we)             swb <= wfield[0];
    end
  end

  AST_SEL_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    sel != DIV_RSVD); // R6
  AST_SLOW_FROM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reject && !sb_evt) |=> $stable(sel)); // R5
  AST_SWITCHBACK: assert property (@(posedge clk) disable iff (!rst_n)
    sb_evt |=> sel == DIV_FAST); // R8
  AST_NO_SWITCHBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!swb && !we) |=> $stable(sel)); // R9
  AST_EVT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_evt && we) |=> sel == DIV_FAST); // R10

endmodule

// File: rtl/mcd_phase_gen.sv
module mcd_phase_gen
  import mcd_pkg::*;
#(
  parameter int unsigned SLOW1_TICKS = 16,
  parameter int unsigned SLOW2_TICKS = 256
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_e sel,
  output logic [3:0] phase_stb,
  output logic     mc_end,
  output div_sel_e act_sel
);

  localparam int CW = (SLOW2_TICKS > 1) ? $clog2(SLOW2_TICKS) : 1;

  logic [CW-1:0] cnt;
  logic [1:0]    phase;
  int unsigned   len;
  logic          phase_last;

  assign len        = ticks_per_phase(act_sel, SLOW1_TICKS, SLOW2_TICKS);
  assign phase_last = (cnt == CW'(len - 1));
  assign mc_end     = phase_last && (phase == 2'd3);

  for (genvar i = 0; i < 4; i++) begin : g_stb
    assign phase_stb[i] = phase_last && (phase == 2'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= 2'd0;
      act_sel <= DIV_FAST;
    end else if (phase_last) begin
      cnt   <= '0;
      phase <= phase + 2'd1;
      if (phase == 2'd3) act_sel <= sel;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_stb)); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < len); // R2
  AST_RESTART_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    mc_end |=> (cnt == '0 && phase == 2'd0)); // R3
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_end |=> $stable(act_sel)); // R11

endmodule

// File: rtl/mcycle_divider.sv
module mcycle_divider
  import mcd_pkg::*;
#(
  parameter int N_IRQ = 5,
  parameter int N_SER = 4,
  parameter int unsigned SLOW1_TICKS = 16,
  parameter int unsigned SLOW2_TICKS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_SER-1:0] ser_act,
  output logic [3:0]       phase_stb,
  output logic             mc_end
);

  div_sel_e sel, act_sel;
  logic     swb, sb_evt, wr_reject;
  logic     wdata_unused;

  assign wdata_unused = ^reg_wdata[4:0];

  mcd_ctrl_reg #(.N_IRQ(N_IRQ), .N_SER(N_SER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wfield(reg_wdata[7:5]),
    .irq_req(irq_req), .ser_act(ser_act),
    .sel(sel), .swb(swb), .sb_evt(sb_evt), .wr_reject(wr_reject)
  );

  mcd_phase_gen #(.SLOW1_TICKS(SLOW1_TICKS), .SLOW2_TICKS(SLOW2_TICKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .phase_stb(phase_stb), .mc_end(mc_end), .act_sel(act_sel)
  );

  assign reg_rdata = {sel, swb, 5'b0};

  AST_ACT_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    act_sel != DIV_RSVD); // R2
  AST_WRITE_SWB: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[5] == $past(reg_wdata[5])); // R7

endmodule

// File: tb/tb_mcycle_divider.sv
module tb_mcycle_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [4:0] irq_req = '0;
  logic [3:0] ser_act = '0;
  logic [3:0] phase_stb;
  logic       mc_end;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mcycle_divider dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .ser_act(ser_act),
    .phase_stb(phase_stb), .mc_end(mc_end)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic sync_end();
    for (int k = 0; k < 3000 && !mc_end; k++) @(negedge clk);
  endtask

  // Clocks from one mc_end to the next (current negedge must show mc_end).
  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!mc_end && n < 3000);
  endtask

  task automatic phase_layout(string req, int plen);
    int pos = 0;
    int nxt = 0;
    sync_end();
    do begin
      @(negedge clk); pos++;
      if (phase_stb != 4'b0) begin
        check(req, phase_stb, 4'b1 << nxt);
        check(req, pos, (nxt + 1) * plen);
        nxt++;
      end
    end while (!mc_end && pos < 3000);
    check(req, nxt, 4);
  endtask

  task automatic t_reset();
    check("R1", reg_rdata, 8'h40);
    check("R3", phase_stb, 4'b0001);
    check("R3", mc_end, 0);
    @(negedge clk);
    check("R3", phase_stb, 4'b0010);
    phase_layout("R2", 1);
  endtask

  task automatic t_slow_modes();
    int n;
    sync_end(); wr(8'h80);
    check("R5", reg_rdata, 8'h80);
    sync_end(); period(n); check("R2", n, 64);
    phase_layout("R3", 16);
    wr(8'hC0);                       // slow to slow: refused
    check("R5", reg_rdata, 8'h80);
    wr(8'h00);                       // reserved: refused
    check("R6", reg_rdata, 8'h80);
    sync_end(); n = 0;               // write fast mid-cycle
    repeat (10) begin @(negedge clk); n++; end
    reg_we = 1'b1; reg_wdata = 8'h40;
    @(negedge clk); n++; reg_we = 1'b0;
    check("R4", reg_rdata, 8'h40);
    while (!mc_end && n < 3000) begin @(negedge clk); n++; end
    check("R11", n, 64);
    period(n); check("R11", n, 4);
    wr(8'hC0);
    check("R5", reg_rdata, 8'hC0);
    sync_end(); period(n); check("R2", n, 1024);
    wr(8'h40); sync_end(); period(n); check("R2", n, 4);
  endtask

  task automatic t_switchback();
    wr(8'hA0);
    check("R7", reg_rdata, 8'hA0);
    irq_req = 5'b00100; @(negedge clk); irq_req = '0;
    check("R8", reg_rdata, 8'h60);
    wr(8'hE0);
    ser_act = 4'b1000; @(negedge clk); ser_act = '0;
    check("R8", reg_rdata, 8'h60);
    wr(8'hA0);                       // slow1, switchback on
    reg_we = 1'b1; reg_wdata = 8'hE0; ser_act = 4'b0001;
    @(negedge clk);
    reg_we = 1'b0; ser_act = '0;
    check("R10", reg_rdata, 8'h60);
    wr(8'h40); wr(8'h80);            // switchback off, slow1
    irq_req = '1; ser_act = '1;
    repeat (3) @(negedge clk);
    irq_req = '0; ser_act = '0;
    check("R9", reg_rdata, 8'h80);
    wr(8'h40);
    check("R7", reg_rdata, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_slow_modes();
    t_switchback();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule